// File: doc/BRIEF.md
# SPI Mode-0 Byte Master with Programmable Data-Line Rest Level

This block is a single-lane SPI master that moves one byte per frame in mode 0: the serial clock rests low, and both sides sample on the rising edge. It drives an active-low select, the serial clock and the outgoing data line, and it samples the incoming data line. A start pulse launches a frame, busy covers the whole frame, and a one-cycle done pulse marks the release of the select.

Some peripherals need the outgoing data line at a defined level whenever no bit is being presented. This holds while the select is released, and also while it is held before the first bit and after the last. A small configuration register picks the rest level: low, high, or a legacy level, which is the last bit sent (or always low when the `LEGACY_FORCE_LOW` parameter is set). A write that asks for low and high together is refused. It raises an error flag, keeps the previous setting, and blocks new frames until a legal write clears the flag.

Top module: `spi_mosi_idle_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy, done and cfg_err are 0.
- R2: tx_byte is sent most significant bit first, eight bits per frame. Each bit is placed on mosi half a clock period before its rising sclk edge and held until the following falling edge (0x56 gives 0,1,0,1,0,1,1,0).
- R3: miso is sampled on each rising sclk edge and assembled MSB first. rx_byte holds the assembled byte from the cycle in which done is high.
- R4: Taking k as the count of system cycles since cs_n fell: cs_n stays low for 18*DIV cycles; the first DIV cycles and the last DIV cycles have sclk low and no data; each bit cell is DIV cycles with sclk low followed by DIV cycles with sclk high. sclk is 0 whenever cs_n is 1.
- R5: busy is 1 from the cycle after an accepted start until cs_n rises. done is high for exactly one cycle, the first cycle in which cs_n is 1 again.
- R6: A start while busy is 1 has no effect on the frame in progress.
- R7: With cfg_mode bit 1 set alone (rest-high), mosi is 1 in every cycle outside a bit cell, whether cs_n is 0 or 1.
- R8: With cfg_mode bit 0 set alone (rest-low), mosi is 0 in every cycle outside a bit cell.
- R9: With cfg_mode 00 (legacy), mosi outside a bit cell equals the last bit sent since reset (0 before any frame). With LEGACY_FORCE_LOW=1 it is 0 instead.
- R10: A write of cfg_mode 11 sets cfg_err, keeps the previous rest level, and makes start ignored while cfg_err is 1. A later legal write clears cfg_err.
- R11: A cfg_we pulse is taken only while busy is 0; the new rest level appears on mosi in the cycle after the write. A write while busy has no effect. A legal write in the same cycle as start applies to that frame, and an illegal one in that cycle refuses the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a frame (ignored when busy or refused) |
| tx_byte | input | 8 | Byte to send, sampled with an accepted start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse as the select is released |
| rx_byte | output | 8 | Last received byte |
| cfg_we | input | 1 | Write strobe for the rest-level setting |
| cfg_mode | input | 2 | Bit 0 requests rest-low, bit 1 requests rest-high |
| cfg_err | output | 1 | Last accepted write was illegal |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, rests low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A configuration write and a start can land in the same idle cycle. In that case the write must decide both whether the frame launches and which rest level the frame's setup and hold intervals show. The bench raises both strobes together with a legal and an illegal mode, in directed and random cases. A legal write must produce a frame whose pre-bit and post-bit cycles show the new level. An illegal one must leave cs_n high with cfg_err set and the old level on mosi.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Rest-level selection; the encoding 2'b11 is illegal and never stored.
  typedef enum logic [1:0] {
    IDLE_LEGACY = 2'b00,
    IDLE_LOW    = 2'b01,
    IDLE_HIGH   = 2'b10
  } idle_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LO    = 3'd2,
    ST_HI    = 3'd3,
    ST_HOLD  = 3'd4
  } xfer_st_e;

endpackage

// File: rtl/spim_cfg.sv
module spim_cfg
  import spim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       wr_en,
  input  logic [1:0] wr_mode,
  output idle_mode_e mode_q,
  output logic       err_q,
  output logic       err_nxt
);

  idle_mode_e mode_d;
  logic       err_d;
  logic       wr_take;

  assign wr_take = wr_en && !busy;

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    if (wr_take) begin
      if (wr_mode == 2'b11) begin
        err_d = 1'b1;
      end else begin
        mode_d = idle_mode_e'(wr_mode);
        err_d  = 1'b0;
      end
    end
  end

  assign err_nxt = err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= IDLE_LEGACY;
      err_q  <= 1'b0;
    end else if (wr_take) begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  // R11
  busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

  // R10
  illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_mode == 2'b11) |=> (err_q && $stable(mode_q)));

endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] tx_data,
  input  logic         tick,
  input  logic         miso,
  output xfer_st_e     state_q,
  output logic         data_bit,
  output logic         last_bit,
  output logic [W-1:0] rx_data,
  output logic         done_q
);

  localparam int BIT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(W - 1);

  xfer_st_e         state_d;
  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rs_q, rs_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [BIT_W-1:0] idx_q, idx_d;
  logic             last_q, last_d;
  logic             done_d;

  always_comb begin
    state_d = state_q;
    tx_d    = tx_q;
    rs_d    = rs_q;
    rx_d    = rx_q;
    idx_d   = idx_q;
    last_d  = last_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_SETUP;
          tx_d    = tx_data;
          idx_d   = TOP_IDX;
        end
      end
      ST_SETUP: if (tick) state_d = ST_LO;
      ST_LO: begin
        if (tick) begin
          state_d = ST_HI;
          rs_d    = {rs_q[W-2:0], miso};
        end
      end
      ST_HI: begin
        if (tick) begin
          last_d = tx_q[W-1];
          tx_d   = {tx_q[W-2:0], 1'b0};
          if (idx_q == '0) begin
            state_d = ST_HOLD;
            rx_d    = rs_q;
          end else begin
            state_d = ST_LO;
            idx_d   = idx_q - 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      rs_q    <= '0;
      rx_q    <= '0;
      idx_q   <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_d;
      rs_q    <= rs_d;
      rx_q    <= rx_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  assign data_bit = tx_q[W-1];
  assign last_bit = last_q;
  assign rx_data  = rx_q;

endmodule

// File: rtl/spim_mosi_sel.sv
module spim_mosi_sel
  import spim_pkg::*;
#(
  parameter bit LEGACY_FORCE_LOW = 1'b0
) (
  input  idle_mode_e mode,
  input  logic       data_cell,
  input  logic       data_bit,
  input  logic       last_bit,
  output logic       mosi
);

  logic legacy_lvl;
  logic rest_lvl;

  generate
    if (LEGACY_FORCE_LOW) begin : g_leg_low
      assign legacy_lvl = 1'b0 & last_bit;
    end else begin : g_leg_keep
      assign legacy_lvl = last_bit;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      IDLE_LOW:  rest_lvl = 1'b0;
      IDLE_HIGH: rest_lvl = 1'b1;
      default:   rest_lvl = legacy_lvl;
    endcase
  end

  assign mosi = data_cell ? data_bit : rest_lvl;

endmodule

// File: rtl/spi_mosi_idle_master.sv
module spi_mosi_idle_master
  import spim_pkg::*;
#(
  parameter int DIV              = 2,
  parameter int W                = 8,
  parameter bit LEGACY_FORCE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_mode,
  output logic         cfg_err,
  output logic         cs_n,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso
);

  idle_mode_e mode_q;
  xfer_st_e   state;
  logic       err_nxt;
  logic       launch;
  logic       tick;
  logic       data_bit;
  logic       last_bit;
  logic       data_cell;

  assign busy      = (state != ST_IDLE);
  assign cs_n      = (state == ST_IDLE);
  assign sclk      = (state == ST_HI);
  assign data_cell = (state == ST_LO) || (state == ST_HI);
  assign launch    = start && !busy && !err_nxt;

  spim_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .wr_en   (cfg_we),
    .wr_mode (cfg_mode),
    .mode_q  (mode_q),
    .err_q   (cfg_err),
    .err_nxt (err_nxt)
  );

  spim_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  spim_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .tx_data  (tx_byte),
    .tick     (tick),
    .miso     (miso),
    .state_q  (state),
    .data_bit (data_bit),
    .last_bit (last_bit),
    .rx_data  (rx_byte),
    .done_q   (done)
  );

  spim_mosi_sel #(.LEGACY_FORCE_LOW(LEGACY_FORCE_LOW)) u_sel (
    .mode      (mode_q),
    .data_cell (data_cell),
    .data_bit  (data_bit),
    .last_bit  (last_bit),
    .mosi      (mosi)
  );

  // R5
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R10
  err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && cs_n && !cfg_we) |=> cs_n);

  // R7
  rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && mode_q == IDLE_HIGH) |-> mosi);

endmodule

// File: tb/spi_mosi_idle_master_tb_top.sv
module spi_mosi_idle_master_tb_top;

  localparam int DIV = 3;
  localparam int FRAME = 18 * DIV;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, start, cfg_we, miso;
  logic [7:0] tx_byte;
  logic [1:0] cfg_mode;
  logic       busy, done, cfg_err, cs_n, sclk, mosi;
  logic [7:0] rx_byte;
  logic       busy_f, done_f, cfg_err_f, cs_n_f, sclk_f, mosi_f;
  logic [7:0] rx_byte_f;

  spi_mosi_idle_master #(.DIV(DIV), .W(8), .LEGACY_FORCE_LOW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte), .busy(busy),
    .done(done), .rx_byte(rx_byte), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_err(cfg_err), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  spi_mosi_idle_master #(.DIV(DIV), .W(8), .LEGACY_FORCE_LOW(1'b1)) dut_fl (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte), .busy(busy_f),
    .done(done_f), .rx_byte(rx_byte_f), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_err(cfg_err_f), .cs_n(cs_n_f), .sclk(sclk_f), .mosi(mosi_f), .miso(miso));

  int checks = 0;
  int fails  = 0;
  int mmode  = 0;
  bit merr   = 1'b0;
  bit mlast  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit rest_lvl(input int md, input bit last, input bit force_low);
    if (md == 1) return 1'b0;
    if (md == 2) return 1'b1;
    return force_low ? 1'b0 : last;
  endfunction

  function automatic string mode_req(input int md);
    if (md == 1) return "R8";
    if (md == 2) return "R7";
    return "R9";
  endfunction

  function automatic void model_cfg(input logic [1:0] v);
    if (v == 2'b11) merr = 1'b1;
    else begin
      mmode = int'(v);
      merr  = 1'b0;
    end
  endfunction

  task automatic check_rest(input string tag);
    chk(mosi == rest_lvl(mmode, mlast, 1'b0), tag, mosi, rest_lvl(mmode, mlast, 1'b0));
    chk(mosi_f == rest_lvl(mmode, mlast, 1'b1), tag, mosi_f, rest_lvl(mmode, mlast, 1'b1));
  endtask

  task automatic cfg_write(input logic [1:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_mode = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    model_cfg(v);
    @(negedge clk);
    chk(cfg_err == merr, "R10", cfg_err, merr);
    check_rest(v == 2'b11 ? "R10" : "R11");
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] pat, input bit poke,
                      input bit same, input logic [1:0] sv);
    int  k;
    int  e_data, e_rest, e_clk, e_fl, e_busy;
    bit  prev_last;
    int  old_mode;
    bit  accepted;
    @(posedge clk); #1;
    start = 1'b1; tx_byte = tx;
    if (same) begin cfg_we = 1'b1; cfg_mode = sv; end
    @(posedge clk); #1;
    start = 1'b0; cfg_we = 1'b0;
    if (same) model_cfg(sv);
    accepted = !merr;
    if (!accepted) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0, same ? "R11" : "R10", cs_n, 1);
      end
      chk(cfg_err == 1'b1, "R10", cfg_err, 1);
      check_rest("R10");
      return;
    end
    prev_last = mlast;
    old_mode  = mmode;
    k = 0; e_data = 0; e_rest = 0; e_clk = 0; e_fl = 0; e_busy = 0;
    forever begin
      @(negedge clk);
      if (cs_n || k > 4 * FRAME) break;
      if (k < DIV || k >= 17 * DIV) begin
        bit lv  = rest_lvl(mmode, (k < DIV) ? prev_last : tx[0], 1'b0);
        bit lvf = rest_lvl(mmode, 1'b0, 1'b1);
        if (mosi !== lv) e_rest++;
        if (mosi_f !== lvf) e_fl++;
        if (sclk !== 1'b0) e_clk++;
        miso = 1'b0;
      end else begin
        int j  = (k - DIV) / (2 * DIV);
        bit ph = ((k - DIV) % (2 * DIV)) >= DIV;
        if (mosi !== tx[7-j]) e_data++;
        if (sclk !== ph) e_clk++;
        miso = pat[7-j];
      end
      if (busy !== 1'b1 || done !== 1'b0) e_busy++;
      if (poke && k == 5) begin
        start = 1'b1; tx_byte = ~tx;
        cfg_we = 1'b1; cfg_mode = (mmode == 2) ? 2'b01 : 2'b11;
      end
      if (poke && k == 6) begin
        start = 1'b0; cfg_we = 1'b0;
      end
      k++;
    end
    mlast = tx[0];
    chk(k == FRAME, "R4", k, FRAME);
    chk(e_clk == 0, "R4", e_clk, 0);
    chk(e_data == 0, "R2", e_data, 0);
    chk(e_rest == 0, mode_req(mmode), e_rest, 0);
    chk(e_fl == 0, "R9", e_fl, 0);
    chk(e_busy == 0, "R5", e_busy, 0);
    chk(done == 1'b1, "R5", done, 1);
    chk(rx_byte == pat, "R3", rx_byte, pat);
    if (poke) begin
      chk(mmode == old_mode && cfg_err == 1'b0, "R11", cfg_err, 0);
      chk(k == FRAME && e_data == 0, "R6", e_data, 0);
    end
    check_rest(mode_req(mmode));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && cs_n == 1'b1, "R5", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd20240626);
    rst_n = 1'b0; start = 1'b0; cfg_we = 1'b0; cfg_mode = 2'b00;
    miso = 1'b0; tx_byte = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", {cs_n, sclk, mosi}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0 && cfg_err == 1'b0, "R1", {busy, done, cfg_err}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && mosi == 1'b0 && mosi_f == 1'b0, "R1", {cs_n, mosi}, 2'b10);

    // legacy: last bit 0 then last bit 1 (R9)
    xfer(8'h56, 8'hBA, 1'b0, 1'b0, 2'b00);
    xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 2'b00);
    // rest-high (R7), rest-low (R8)
    cfg_write(2'b10);
    xfer(8'h56, 8'hC3, 1'b0, 1'b0, 2'b00);
    cfg_write(2'b01);
    xfer(8'hFF, 8'h01, 1'b0, 1'b0, 2'b00);
    // illegal write keeps rest-low, start refused (R10)
    cfg_write(2'b11);
    xfer(8'h81, 8'h7E, 1'b0, 1'b0, 2'b00);
    cfg_write(2'b10);
    // start and write while busy (R6, R11)
    xfer(8'h00, 8'hFF, 1'b1, 1'b0, 2'b00);
    // same-cycle write and start (R11)
    xfer(8'h5A, 8'h96, 1'b0, 1'b1, 2'b01);
    xfer(8'h33, 8'h44, 1'b0, 1'b1, 2'b11);
    xfer(8'h33, 8'h44, 1'b0, 1'b1, 2'b00);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] rv;
      rv = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) cfg_write(rv);
      rv = 2'($urandom_range(0, 3));
      xfer(8'($urandom), 8'($urandom), ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 4) == 0), rv);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule